// File: doc/BRIEF.md
# Column-Serial Configuration Memory Loader

This block fills a two-dimensional grid of configuration cells from a one-bit serial stream, with no address decoding. A column-wide shift register collects one column's worth of bits. When the last bit of a column arrives, all of them are written into the column that a walking pointer currently selects. The pointer then steps one column to the left. The pointer starts at the rightmost column and ends at column 0, so the order of bits in the stream follows the physical layout of the grid.

The grid is divided into tile regions. Some positions inside each region have no cell. The stream still spends one bit on each of these positions, but the bit is dropped. Any column can be read in parallel at any time through a peek port. A column can also be sent back out serially through the same shift register, in the order it was loaded.

The serial input is a valid/ready stream. `in_ready` is high only while a load is in progress, and a bit moves on every rising edge where `in_valid` and `in_ready` are both high. The serial readback output is also valid/ready. While `out_valid` is high and `out_ready` is low, the output bit and `out_valid` hold still. The start, request and done pins are plain single-cycle signals.

Top module: `cfg_column_loader`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `cfg_done` are low, and every cell reads 0 through the peek port.
- R2: `cfg_start` begins a load. `in_ready` then stays high until the bit that completes column 0 is accepted, and drops in the cycle after that.
- R3: Within each group of ROWS accepted bits, the k-th bit (k counted from 0) lands in row ROWS-1-k. The target column keeps its old contents until the last bit of the group is accepted. The whole column changes on that edge.
- R4: The first group goes to column COLS-1. Each later group goes to the column one index lower, and column 0 is the last one filled.
- R5: `cfg_done` is high for exactly one cycle, the cycle after column 0 is written. After that, `in_valid` has no effect on the grid until the next `cfg_start`.
- R6: The cell at column c, row r is vacant when (c mod 18) equals 2*(r mod 8)+1. A vacant cell always reads 0, and the stream bit aimed at it is dropped.
- R7: In the idle phase, `rb_req` with `rb_col` < COLS raises `out_valid` in the next cycle. The block then emits that column's ROWS bits, row ROWS-1 first, one per accepted transfer, and `out_valid` falls after the last one. A request with `rb_col` >= COLS is ignored.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold their values.
- R9: `cfg_start` restarts loading from column COLS-1 in any phase. A partly collected column is discarded, and so is any bit offered in the start cycle.
- R10: `rb_req` has no effect while a load is in progress.
- R11: Cycles with `in_valid` low do not advance the row position or the column pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Begin (or restart) a full load |
| in_valid | input | 1 | Serial input bit is offered |
| in_ready | output | 1 | Loader accepts serial bits |
| in_bit | input | 1 | Serial configuration bit |
| cfg_done | output | 1 | One-cycle pulse after the final column is written |
| rb_req | input | 1 | Request serial readback of one column |
| rb_col | input | CW | Column to read back |
| out_valid | output | 1 | Readback bit is offered |
| out_ready | input | 1 | Consumer takes the readback bit |
| out_bit | output | 1 | Serial readback bit |
| peek_col | input | CW | Column selected for parallel read |
| peek_data | output | ROWS | Parallel contents of the peeked column |

## Verification
Two things are hard to reach from the ports. One is the edge where the last row bit of a column is accepted: the column has to stay unchanged for all earlier bits and then change on that edge alone. The other is a restart that lands on a partly filled column. The stimulus runs a short first load that stops partway into the second column. It watches the first column just before and just after its final bit, then restarts and streams a full pattern with random gaps in `in_valid`. Every cell is then compared with its expected position. Readback runs under random back-pressure, so stalls land on arbitrary bit positions.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_READ
  } phase_e;

  // A grid position has no storage cell when this holds.
  function automatic logic cell_vacant(input int c, input int r,
                                       input int tw, input int th);
    return (c % tw) == (2 * (r % th) + 1);
  endfunction

endpackage

// File: rtl/cfgld_col_shifter.sv
module cfgld_col_shifter #(
  parameter int ROWS = 71
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            shift_en,
  input  logic            ser_in,
  input  logic            load_en,
  input  logic [ROWS-1:0] par_in,
  output logic [ROWS-1:0] shift_word,
  output logic            ser_out,
  output logic            last
);

  localparam int CNT_W = $clog2(ROWS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ROWS - 1);

  logic [ROWS-1:0]  word_q;
  logic [CNT_W-1:0] pos_q;

  // The incoming bit enters at row 0; earlier bits move toward the top row.
  assign shift_word = {word_q[ROWS-2:0], ser_in};
  assign ser_out    = word_q[ROWS-1];
  assign last       = (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      pos_q  <= '0;
    end else if (load_en) begin
      word_q <= par_in;
      pos_q  <= '0;
    end else if (clear) begin
      pos_q  <= '0;
    end else if (shift_en) begin
      word_q <= shift_word;
      pos_q  <= last ? '0 : pos_q + 1'b1;
    end
  end

  p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && last && !load_en && !clear) |=> (pos_q == '0));

endmodule

// File: rtl/cfgld_col_walker.sv
module cfgld_col_walker #(
  parameter int COLS = 160,
  localparam int CW  = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic          at_first
);

  localparam logic [CW-1:0] TOP_COL = CW'(COLS - 1);

  logic [CW-1:0] col_q;

  assign col      = col_q;
  assign at_first = (col_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= TOP_COL;
    end else if (init) begin
      col_q <= TOP_COL;
    end else if (step && !at_first) begin
      col_q <= col_q - 1'b1;
    end
  end

  p_col_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= TOP_COL);

  p_init_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (col_q == TOP_COL));

endmodule

// File: rtl/cfgld_cell_array.sv
module cfgld_cell_array
  import cfgld_pkg::*;
#(
  parameter int COLS   = 160,
  parameter int ROWS   = 71,
  parameter int TILE_W = 18,
  parameter int TILE_H = 8,
  localparam int CW    = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CW-1:0]   wcol,
  input  logic [ROWS-1:0] wdata,
  input  logic [CW-1:0]   rcol_a,
  output logic [ROWS-1:0] rdata_a,
  input  logic [CW-1:0]   rcol_b,
  output logic [ROWS-1:0] rdata_b
);

  typedef logic [COLS-1:0][ROWS-1:0] grid_t;

  function automatic grid_t build_keep();
    grid_t k;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        k[c][r] = !cell_vacant(c, r, TILE_W, TILE_H);
      end
    end
    return k;
  endfunction

  localparam grid_t KEEP = build_keep();

  grid_t cells_q;
  logic  a_ok, b_ok;

  assign a_ok = ({1'b0, rcol_a} < (CW+1)'(COLS));
  assign b_ok = ({1'b0, rcol_b} < (CW+1)'(COLS));

  // Each row line reaches every column; the select decides which column latches.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells_q <= '0;
    end else if (we) begin
      cells_q[wcol] <= wdata & KEEP[wcol];
    end
  end

  always_comb begin
    rdata_a = a_ok ? cells_q[rcol_a] : '0;
    rdata_b = b_ok ? cells_q[rcol_b] : '0;
  end

  p_vacant_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_ok |-> ((rdata_a & ~KEEP[rcol_a]) == '0));

  p_write_column_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && a_ok && rcol_a == wcol) |=> $stable(rcol_a) |-> (rdata_a == ($past(wdata) & KEEP[rcol_a])));

endmodule

// File: rtl/cfg_column_loader.sv
module cfg_column_loader
  import cfgld_pkg::*;
#(
  parameter int COLS   = 160,
  parameter int ROWS   = 71,
  parameter int TILE_W = 18,
  parameter int TILE_H = 8,
  localparam int CW    = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  output logic            cfg_done,
  input  logic            rb_req,
  input  logic [CW-1:0]   rb_col,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_bit,
  input  logic [CW-1:0]   peek_col,
  output logic [ROWS-1:0] peek_data
);

  phase_e          ph_q;
  logic            done_q;
  logic            sh_last, sh_ser;
  logic [ROWS-1:0] sh_word, rb_word;
  logic [CW-1:0]   sel_col;
  logic            at_first;
  logic            rb_ok, rb_take, load_fire, read_fire, col_write;

  assign rb_ok     = ({1'b0, rb_col} < (CW+1)'(COLS));
  assign rb_take   = (ph_q == PH_IDLE) && rb_req && rb_ok && !cfg_start;
  assign load_fire = (ph_q == PH_LOAD) && in_valid && !cfg_start;
  assign read_fire = (ph_q == PH_READ) && out_ready && !cfg_start;
  assign col_write = load_fire && sh_last;

  assign in_ready  = (ph_q == PH_LOAD);
  assign out_valid = (ph_q == PH_READ);
  assign out_bit   = sh_ser;
  assign cfg_done  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= col_write && at_first;
      if (cfg_start) begin
        ph_q <= PH_LOAD;
      end else begin
        unique case (ph_q)
          PH_IDLE: if (rb_take) ph_q <= PH_READ;
          PH_LOAD: if (col_write && at_first) ph_q <= PH_IDLE;
          PH_READ: if (read_fire && sh_last) ph_q <= PH_IDLE;
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  cfgld_col_shifter #(.ROWS(ROWS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cfg_start),
    .shift_en   (load_fire || read_fire),
    .ser_in     ((ph_q == PH_LOAD) ? in_bit : 1'b0),
    .load_en    (rb_take),
    .par_in     (rb_word),
    .shift_word (sh_word),
    .ser_out    (sh_ser),
    .last       (sh_last)
  );

  cfgld_col_walker #(.COLS(COLS)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (cfg_start),
    .step     (col_write),
    .col      (sel_col),
    .at_first (at_first)
  );

  cfgld_cell_array #(
    .COLS   (COLS),
    .ROWS   (ROWS),
    .TILE_W (TILE_W),
    .TILE_H (TILE_H)
  ) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (col_write),
    .wcol    (sel_col),
    .wdata   (sh_word),
    .rcol_a  (peek_col),
    .rdata_a (peek_data),
    .rcol_b  (rb_col),
    .rdata_b (rb_word)
  );

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done);

  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> $past(col_write && at_first));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_start) |=> (out_valid && $stable(out_bit)));

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_write && at_first) |=> !in_ready);

endmodule

// File: tb/test_cfg_column_loader.sv
module test_cfg_column_loader;

  localparam int CLK_T = 10;
  localparam int COLS  = 160;
  localparam int ROWS  = 71;
  localparam int CW    = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_start = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_bit = 1'b0;
  logic            cfg_done;
  logic            rb_req = 1'b0;
  logic [CW-1:0]   rb_col = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic            out_bit;
  logic [CW-1:0]   peek_col = '0;
  logic [ROWS-1:0] peek_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_q[$];
  int seed_b;

  always #(CLK_T/2) clk = ~clk;

  cfg_column_loader i_cfg_column_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .cfg_done  (cfg_done),
    .rb_req    (rb_req),
    .rb_col    (rb_col),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .peek_col  (peek_col),
    .peek_data (peek_data)
  );

  function automatic bit pat(int seed, int c, int r);
    logic [31:0] x;
    x = 32'(c) * 32'd40503 + 32'(r) * 32'd2654435 + 32'(seed) * 32'd977;
    x = x ^ (x >> 13);
    x = x * 32'h5bd1e995;
    x = x ^ (x >> 15);
    return x[7];
  endfunction

  function automatic bit vac(int c, int r);
    return (c % 18) == (2 * (r % 8) + 1);
  endfunction

  function automatic logic [ROWS-1:0] exp_col(int seed, int c);
    logic [ROWS-1:0] w;
    for (int r = 0; r < ROWS; r++) w[r] = vac(c, r) ? 1'b0 : pat(seed, c, r);
    return w;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Streams nbits of a pattern; bit index i targets column COLS-1-i/ROWS, row ROWS-1-i%ROWS.
  task automatic load_stream(int seed, int nbits, bit first_watch, bit full);
    int idx = 0;
    bit fire;
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    peek_col = CW'(COLS - 1);
    while (idx < nbits) begin
      @(negedge clk);
      if (first_watch && idx == ROWS - 1) begin
        #1;
        chk(peek_data == '0, "R3", "column before final row bit", peek_data, 0);
      end
      if (first_watch && idx == ROWS) begin
        #1;
        chk(peek_data == exp_col(seed, COLS - 1), "R3", "column after final row bit",
            peek_data, exp_col(seed, COLS - 1));
      end
      in_valid = ($urandom % 4) != 0;
      in_bit   = pat(seed, COLS - 1 - idx / ROWS, ROWS - 1 - idx % ROWS);
      fire     = in_valid && in_ready;
      if (idx < nbits - 1) chk(in_ready == 1'b1, "R2", "in_ready during load", in_ready, 1);
      @(posedge clk);
      if (fire) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (full) begin
      chk(cfg_done == 1'b1, "R5", "done after column 0", cfg_done, 1);
      chk(in_ready == 1'b0, "R2", "in_ready after last column", in_ready, 0);
      @(negedge clk);
      chk(cfg_done == 1'b0, "R5", "done lasts one cycle", cfg_done, 0);
    end
  endtask

  task automatic readback(int c);
    @(negedge clk);
    rb_col = CW'(c);
    rb_req = 1'b1;
    for (int r = ROWS - 1; r >= 0; r--) exp_q.push_back(vac(c, r) ? 1'b0 : pat(seed_b, c, r));
    @(negedge clk);
    rb_req = 1'b0;
    chk(out_valid == 1'b1, "R7", "out_valid after request", out_valid, 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "out_valid falls after last bit", out_valid, 0);
  endtask

  // Scoreboard monitor: owns out_ready, pops an expected bit for every transfer.
  initial begin
    bit prev_stall = 1'b0;
    bit prev_bit   = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_stall)
        chk(out_valid && out_bit == prev_bit, "R8", "hold under back-pressure",
            {out_valid, out_bit}, {1'b1, prev_bit});
      out_ready = ($urandom % 2) != 0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected readback bit", out_bit, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(out_bit == e, "R7", "readback bit order", out_bit, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    int seed_a;
    seed_a = int'($urandom % 1000) + 1;
    seed_b = seed_a + 4099;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b0, "R1", "in_ready at reset", in_ready, 0);
    chk(out_valid == 1'b0, "R1", "out_valid at reset", out_valid, 0);
    chk(cfg_done == 1'b0, "R1", "done at reset", cfg_done, 0);
    for (int c = 0; c < COLS; c += 53) begin
      peek_col = CW'(c);
      #1;
      chk(peek_data == '0, "R1", "cell contents at reset", peek_data, 0);
    end

    // Partial load, then readback request ignored while loading (R10)
    load_stream(seed_a, ROWS + 29, 1'b1, 1'b0);
    @(negedge clk); rb_col = 8'd5; rb_req = 1'b1;
    @(negedge clk); rb_req = 1'b0;
    chk(out_valid == 1'b0, "R10", "no readback during load", out_valid, 0);
    chk(in_ready == 1'b1, "R10", "load continues after request", in_ready, 1);

    // Restart mid column (R9) and stream the full grid with gaps (R11)
    load_stream(seed_b, COLS * ROWS, 1'b0, 1'b1);

    // R5: input after done has no effect
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = ~pat(seed_b, 0, ROWS - 1 - i);
      chk(in_ready == 1'b0, "R5", "in_ready low after done", in_ready, 0);
    end
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);

    // R3 R4 R6 R9 R11: every cell at its expected position
    for (int c = 0; c < COLS; c++) begin
      peek_col = CW'(c);
      #1;
      for (int r = 0; r < ROWS; r++) begin
        bit e;
        e = vac(c, r) ? 1'b0 : pat(seed_b, c, r);
        if (vac(c, r))
          chk(peek_data[r] == 1'b0, "R6", $sformatf("vacant cell c%0d r%0d", c, r), peek_data[r], 0);
        else
          chk(peek_data[r] == e, "R4", $sformatf("cell c%0d r%0d", c, r), peek_data[r], e);
      end
    end

    // R7 R8: serial readback under random back-pressure
    readback(COLS - 1);
    readback(0);
    readback(77);
    readback(19);

    // R7: out-of-range request ignored
    @(negedge clk); rb_col = 8'd200; rb_req = 1'b1;
    @(negedge clk); rb_req = 1'b0;
    chk(out_valid == 1'b0, "R7", "out-of-range request ignored", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "still idle after bad request", out_valid, 0);

    finish_run();
  end

endmodule